// File: doc/BRIEF.md
# Dual-Output Compare Waveform Timer

This block is one timer channel. A single up-counter drives two waveform outputs, A and B. Both outputs run on one period, because they share the period register. Each output has its own duty compare register. A mode register does two jobs. It picks the count clock source, and it gives each output a 2-bit action for each of its three events: its own duty match, the period match and a software trigger. One counter can therefore make two pulse-width modulated outputs of equal period. Their duties and polarities can differ, and an output can also be held at a constant level.

Software sends commands through a 3-bit command input that is pulsed for one cycle. The commands are enable, disable and trigger. A trigger forces both output levels and sends the counter back to zero, so enable plus trigger starts a clean waveform. Disable plus trigger parks the outputs at a known level and then stops. A small control machine has two states. `ST_HALT` means the counter is frozen. `ST_RUN` means the counter advances on each count tick. The machine moves from `ST_HALT` to `ST_RUN` on an enable without a disable, and from `ST_RUN` to `ST_HALT` on a disable. In every other case it stays where it is.

The count tick comes from a free-running prescaler that divides the main clock. An external slow-tick enable can be chosen instead.

Top module: `dual_cmp_timer`

## Requirements
- R1: While running, the counter adds one on each count tick. On the tick where the count equals the period register, it returns to 0 instead. While halted, or when no tick occurs, it holds its value.
- R2: Output A reacts to a duty A match and output B reacts to a duty B match. Both react to the period match. A match is an event only on a count tick while running. Each action field codes 0 = none, 1 = set, 2 = clear, 3 = toggle.
- R3: A trigger (command bit 2) applies each output's trigger action and loads 0 into the counter on the next edge. This happens in either state, and the counter does not advance in that cycle.
- R4: Command bit 0 is enable and command bit 1 is disable. Disable wins when both are set. While halted, the counter and both outputs hold their values.
- R5: Clock select 0..3 picks the main clock divided by 2, 8, 32 or 128. The prescaler is a 7-bit counter that is zeroed by reset and adds one every cycle. A divided tick is high when the prescaler's low 1, 3, 5 or 7 bits are all ones. Select 4 uses the `slow_tick` input, and selects 5..7 give no ticks.
- R6: When several events reach one output in the same cycle, the trigger acts first. The period match comes next and the duty match last.
- R7: An output with no duty or period action keeps the level set by the last trigger. This gives a constant 0% or 100% output.
- R8: With duty action clear, period action set and trigger action set, output A is high while the count is in 0..D and low while it is in D+1..P. The inverse actions give the inverted waveform.
- R9: Writes decode as follows: address 0 = mode, 1 = period, 2 = duty A, 3 = duty B. The mode bit layout is:
  - select in bits [2:0]
  - A duty action in bits [4:3], A period action in [6:5], A trigger action in [8:7]
  - B duty action in bits [10:9], B period action in [12:11], B trigger action in [14:13]

  Writes are accepted in either state, and a new value is used from the next cycle.
- R10: After reset the block is halted, with count 0, both outputs 0 and all registers 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | WD_W | Write data (the larger of CNT_W and 15) |
| cmd | input | 3 | One-cycle command pulse: enable, disable, trigger |
| slow_tick | input | 1 | External slow count enable |
| out_a | output | 1 | Waveform output A |
| out_b | output | 1 | Waveform output B |
| count | output | CNT_W | Current counter value |

## Verification
The hardest cases are the coincident events. A trigger or a period match must land in the very cycle where a duty match also occurs. With a divided clock, that cycle depends on the prescaler phase. To reach these cases, the stimulus sets the duty registers equal to the period and sends triggers at a range of offsets. A behavioural model in the bench then decides every cycle which event wins. Stopping, writing while halted and restarting are also stepped through with both the stale and the fresh compare values.

// File: rtl/dct_pkg.sv
package dct_pkg;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_SET  = 2'd1,
        ACT_CLR  = 2'd2,
        ACT_TGL  = 2'd3
    } act_e;

    typedef enum logic {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } run_st_e;

    // per-output action set: trigger, period, duty (duty in the low bits)
    typedef struct packed {
        act_e sw;
        act_e per;
        act_e cmp;
    } chan_act_t;

    localparam int SEL_W  = 3;
    localparam int NDIV   = 4;
    localparam int PRE_W  = 2 * NDIV - 1;
    localparam int NCHAN  = 2;
    localparam int MODE_W = SEL_W + NCHAN * $bits(chan_act_t);

    typedef struct packed {
        chan_act_t        b;
        chan_act_t        a;
        logic [SEL_W-1:0] sel;
    } mode_t;

    localparam int CMD_W   = 3;
    localparam int CMD_EN  = 0;
    localparam int CMD_DIS = 1;
    localparam int CMD_TRG = 2;

    localparam logic [1:0] ADR_MODE = 2'd0;
    localparam logic [1:0] ADR_PER  = 2'd1;
    localparam logic [1:0] ADR_DA   = 2'd2;
    localparam logic [1:0] ADR_DB   = 2'd3;

    localparam logic [SEL_W-1:0] SEL_SLOW = 3'd4;

    function automatic logic act_apply(input act_e a, input logic cur);
        case (a)
            ACT_SET: act_apply = 1'b1;
            ACT_CLR: act_apply = 1'b0;
            ACT_TGL: act_apply = ~cur;
            default: act_apply = cur;
        endcase
    endfunction

endpackage

// File: rtl/dct_prescaler.sv
module dct_prescaler
    import dct_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    input  logic             slow_tick,
    output logic             tick
);

    logic [PRE_W-1:0] pcount;
    logic [NDIV-1:0]  div_tick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pcount <= '0;
        else        pcount <= pcount + 1'b1;
    end

    for (genvar g = 0; g < NDIV; g++) begin : g_div
        assign div_tick[g] = &pcount[2*g:0];
    end

    always_comb begin
        if (sel < SEL_W'(NDIV))  tick = div_tick[sel[1:0]];
        else if (sel == SEL_SLOW) tick = slow_tick;
        else                      tick = 1'b0;
    end

    // divided ticks are single-cycle pulses
    assert_div_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && sel < SEL_W'(NDIV)) |=> !(tick && sel < SEL_W'(NDIV)));

endmodule

// File: rtl/dct_regs.sv
module dct_regs
    import dct_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int WD_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [WD_W-1:0]  wr_data,
    output mode_t            mode,
    output logic [CNT_W-1:0] per,
    output logic [CNT_W-1:0] duty_a,
    output logic [CNT_W-1:0] duty_b
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode   <= '0;
            per    <= '0;
            duty_a <= '0;
            duty_b <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                ADR_MODE: mode   <= mode_t'(wr_data[MODE_W-1:0]);
                ADR_PER:  per    <= wr_data[CNT_W-1:0];
                ADR_DA:   duty_a <= wr_data[CNT_W-1:0];
                ADR_DB:   duty_b <= wr_data[CNT_W-1:0];
                default:  ;
            endcase
        end
    end

    assert_write_per_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADR_PER) |=> per == $past(wr_data[CNT_W-1:0]));

endmodule

// File: rtl/dct_ctrl.sv
module dct_ctrl
    import dct_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CMD_W-1:0] cmd,
    input  logic [CNT_W-1:0] per,
    input  logic [CNT_W-1:0] duty_a,
    input  logic [CNT_W-1:0] duty_b,
    output logic [CNT_W-1:0] count,
    output logic             trg,
    output logic             per_ev,
    output logic [NCHAN-1:0] cmp_ev
);

    run_st_e st, st_nx;
    logic    adv;

    assign trg = cmd[CMD_TRG];

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_HALT: if (cmd[CMD_EN] && !cmd[CMD_DIS]) st_nx = ST_RUN;
            ST_RUN:  if (cmd[CMD_DIS])                 st_nx = ST_HALT;
            default: st_nx = ST_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_HALT;
        else        st <= st_nx;
    end

    assign adv       = (st == ST_RUN) && tick && !trg;
    assign per_ev    = adv && (count == per);
    assign cmp_ev[0] = adv && (count == duty_a);
    assign cmp_ev[1] = adv && (count == duty_b);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      count <= '0;
        else if (trg)    count <= '0;
        else if (per_ev) count <= '0;
        else if (adv)    count <= count + 1'b1;
    end

    assert_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        per_ev |=> count == '0);
    assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && count != per) |=> count == $past(count) + 1'b1);
    assert_trig_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        trg |=> count == '0);
    assert_halt_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HALT && !trg) |=> $stable(count));

endmodule

// File: rtl/dct_wave.sv
module dct_wave
    import dct_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      trg,
    input  logic      per_ev,
    input  logic      cmp_ev,
    input  chan_act_t act,
    output logic      out
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      out <= 1'b0;
        else if (trg)    out <= act_apply(act.sw, out);
        else if (per_ev) out <= act_apply(act.per, out);
        else if (cmp_ev) out <= act_apply(act.cmp, out);
    end

    assert_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(trg || per_ev || cmp_ev) |=> $stable(out));
    assert_trig_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (trg && act.sw == ACT_SET) |=> out);
    assert_per_over_cmp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!trg && per_ev && act.per == ACT_CLR) |=> !out);

endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer
    import dct_pkg::*;
#(
    parameter int   CNT_W = 16,
    localparam int  WD_W  = (CNT_W > MODE_W) ? CNT_W : MODE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [WD_W-1:0]  wr_data,
    input  logic [CMD_W-1:0] cmd,
    input  logic             slow_tick,
    output logic             out_a,
    output logic             out_b,
    output logic [CNT_W-1:0] count
);

    mode_t            mode;
    logic [CNT_W-1:0] per, duty_a, duty_b;
    logic             tick, trg, per_ev;
    logic [NCHAN-1:0] cmp_ev;
    logic [NCHAN-1:0] wave;
    chan_act_t        acts [NCHAN];

    dct_regs #(.CNT_W(CNT_W), .WD_W(WD_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .mode(mode), .per(per),
        .duty_a(duty_a), .duty_b(duty_b)
    );

    dct_prescaler u_pre (
        .clk(clk), .rst_n(rst_n), .sel(mode.sel),
        .slow_tick(slow_tick), .tick(tick)
    );

    dct_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cmd(cmd),
        .per(per), .duty_a(duty_a), .duty_b(duty_b),
        .count(count), .trg(trg), .per_ev(per_ev), .cmp_ev(cmp_ev)
    );

    assign acts[0] = mode.a;
    assign acts[1] = mode.b;

    for (genvar c = 0; c < NCHAN; c++) begin : g_chan
        dct_wave u_wave (
            .clk(clk), .rst_n(rst_n), .trg(trg), .per_ev(per_ev),
            .cmp_ev(cmp_ev[c]), .act(acts[c]), .out(wave[c])
        );
    end

    assign out_a = wave[0];
    assign out_b = wave[1];

endmodule

// File: tb/dual_cmp_timer_tb.sv
module dual_cmp_timer_tb;

    localparam int CNT_W  = 16;
    localparam int WD_W   = 16;
    localparam int CLK_NS = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [1:0]       wr_addr = '0;
    logic [WD_W-1:0]  wr_data = '0;
    logic [2:0]       cmd = '0;
    logic             slow_tick = 1'b0;
    logic             out_a, out_b;
    logic [CNT_W-1:0] count;

    int    checks = 0;
    int    failures = 0;
    int    cycles = 0;
    bit    done = 1'b0;
    string cur_req = "R10";

    // reference model state
    logic [CNT_W-1:0] m_cnt, m_rc, m_ra, m_rb;
    int               m_mode, m_pre;
    bit               m_run, m_a, m_b;

    dual_cmp_timer #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cmd(cmd), .slow_tick(slow_tick),
        .out_a(out_a), .out_b(out_b), .count(count)
    );

    always #(CLK_NS/2) clk = ~clk;

    function automatic int act_of(int mode, int ch, int ev);
        return (mode >> (3 + 6*ch + 2*ev)) & 3;
    endfunction

    function automatic bit app(int a, bit cur);
        if (a == 1) return 1'b1;
        if (a == 2) return 1'b0;
        if (a == 3) return ~cur;
        return cur;
    endfunction

    function automatic int mk(int sel, int ac, int ap, int as, int bc, int bp, int bs);
        return sel | (ac << 3) | (ap << 5) | (as << 7) | (bc << 9) | (bp << 11) | (bs << 13);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = '0; m_rc = '0; m_ra = '0; m_rb = '0;
            m_mode = 0; m_pre = 0; m_run = 0; m_a = 0; m_b = 0;
        end else begin
            int sel, n;
            bit tk, trg, adv, pe, ca, cb;
            sel = m_mode & 7;
            tk = 0;
            if (sel < 4) begin
                n = 1 << (1 + 2*sel);
                tk = ((m_pre % n) == n - 1);
            end else if (sel == 4) tk = slow_tick;
            m_pre = (m_pre + 1) % 128;
            trg = cmd[2];
            adv = m_run && tk && !trg;
            pe  = adv && (m_cnt == m_rc);
            ca  = adv && (m_cnt == m_ra);
            cb  = adv && (m_cnt == m_rb);
            if (trg)     m_a = app(act_of(m_mode, 0, 2), m_a);
            else if (pe) m_a = app(act_of(m_mode, 0, 1), m_a);
            else if (ca) m_a = app(act_of(m_mode, 0, 0), m_a);
            if (trg)     m_b = app(act_of(m_mode, 1, 2), m_b);
            else if (pe) m_b = app(act_of(m_mode, 1, 1), m_b);
            else if (cb) m_b = app(act_of(m_mode, 1, 0), m_b);
            if (trg)      m_cnt = '0;
            else if (pe)  m_cnt = '0;
            else if (adv) m_cnt = m_cnt + 1'b1;
            if (cmd[1])      m_run = 0;
            else if (cmd[0]) m_run = 1;
            if (wr_en) begin
                case (wr_addr)
                    2'd0: m_mode = int'(wr_data[14:0]);
                    2'd1: m_rc = wr_data;
                    2'd2: m_ra = wr_data;
                    default: m_rb = wr_data;
                endcase
            end
        end
    end

    task automatic chk(bit ok, string what, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", cur_req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(count === m_cnt, "count", int'(count), int'(m_cnt));
            chk(out_a === m_a, "out_a", int'(out_a), int'(m_a));
            chk(out_b === m_b, "out_b", int'(out_b), int'(m_b));
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [1:0] a, int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = WD_W'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic command(logic [2:0] c);
        @(negedge clk);
        cmd = c;
        @(negedge clk);
        cmd = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 60000 && !done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 60000);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R10: reset state compared against the model
        idle(4);

        // R8: normal PWM on A (duty clear, period set), inverted on B
        cur_req = "R8";
        wr(2'd0, mk(0, 2, 1, 1, 1, 2, 2));
        wr(2'd1, 9); wr(2'd2, 3); wr(2'd3, 6);
        command(3'b101);
        idle(90);

        // R2: toggle actions at divide-by-8
        cur_req = "R2";
        wr(2'd0, mk(1, 3, 0, 2, 0, 3, 1));
        command(3'b100);
        idle(240);

        // R6: duty equals period so both events coincide
        cur_req = "R6";
        command(3'b100);
        wr(2'd0, mk(0, 1, 2, 1, 2, 3, 2));
        wr(2'd1, 5); wr(2'd2, 5); wr(2'd3, 5);
        idle(40);
        // R3: triggers at varied offsets, some on a period match
        cur_req = "R3";
        for (int k = 1; k < 14; k++) begin
            idle(k);
            command(3'b100);
        end
        idle(20);

        // R7: no compare actions, constant levels from the trigger
        cur_req = "R7";
        wr(2'd0, mk(0, 0, 0, 1, 0, 0, 2));
        command(3'b100);
        idle(50);
        wr(2'd0, mk(0, 0, 0, 2, 0, 0, 1));
        command(3'b100);
        idle(30);

        // R4: stop, write while halted, restart, hold, disable dominance
        cur_req = "R4";
        wr(2'd0, mk(0, 2, 1, 1, 1, 2, 2));
        wr(2'd1, 9); wr(2'd2, 4); wr(2'd3, 7);
        idle(15);
        command(3'b110);
        idle(20);
        wr(2'd2, 2);
        command(3'b001);
        idle(30);
        command(3'b010);
        idle(15);
        command(3'b001);
        idle(20);
        command(3'b011);
        idle(12);
        command(3'b001);
        idle(20);

        // R9: duty change while running takes effect at the next compare
        cur_req = "R9";
        wr(2'd3, 1);
        idle(30);
        wr(2'd2, 8);
        idle(30);

        // R5: clock source selection
        cur_req = "R5";
        wr(2'd0, mk(2, 2, 1, 1, 1, 2, 2));
        idle(700);
        wr(2'd0, mk(3, 2, 1, 1, 1, 2, 2));
        wr(2'd1, 3); wr(2'd2, 1); wr(2'd3, 2);
        command(3'b100);
        idle(1300);
        wr(2'd0, mk(4, 2, 1, 1, 1, 2, 2));
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            slow_tick = ((k % 3) == 0) || ((k % 7) == 2);
        end
        @(negedge clk) slow_tick = 1'b0;
        wr(2'd0, mk(5, 2, 1, 1, 1, 2, 2));
        idle(40);
        wr(2'd0, mk(7, 2, 1, 1, 1, 2, 2));
        idle(20);

        // R1: long period with wrap at divide-by-2
        cur_req = "R1";
        command(3'b100);
        wr(2'd0, mk(0, 2, 1, 1, 1, 2, 2));
        wr(2'd1, 20); wr(2'd2, 0); wr(2'd3, 20);
        idle(100);

        finish_run();
    end

endmodule